// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets an external host read and write a small bank of byte-wide registers over three wires: a serial clock, an active-low select and a single data line. The data line is split into an input, an output and an output enable, so the line can turn around for readback. All three serial pins are oversampled by the system clock through synchronizers. The block reacts to edges it sees on the serial clock and the select, so it needs no clock domain of its own.

A frame opens with a 16-bit command. The command holds a read flag, a two-bit length code and a 13-bit start address. Data bytes follow the command. The length code asks for either one to three bytes or an open-ended stream. The address steps once per byte. The host may raise the select between bytes to pause a fixed-length transfer. Raising it partway through a byte throws the frame away. Register 0 holds the bit-order control. Core logic reads every register through a separate combinational port.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, spi_sdo_en is 0. Every register reads 0x00. The port uses MSB-first order.
- R2: While spi_csn is low, spi_sdi is sampled on each rising edge of spi_sclk. The first 16 sampled bits form the command: bit 15 is the read flag (1 = read), bits 14:13 are the length code and bits 12:0 are the start address. Clock edges seen while spi_csn is high have no effect.
- R3: Length codes 00, 01 and 10 move 1, 2 and 3 bytes and then close the frame. If spi_csn stays low, the next bits are taken as a new command.
- R4: Length code 11 streams bytes until spi_csn rises. If spi_csn never rises, every later bit stays data until reset, including bits that look like a command.
- R5: After each data byte the address steps by one. It goes down in MSB-first order and up in LSB-first order.
- R6: A write byte is stored when its eighth bit is sampled. Only addresses below NUM_REGS exist. A write to any other address changes nothing, including the register whose low address bits match, and a read of such an address returns 0x00.
- R7: In a read frame, spi_sdo_en stays 0 during the command and is 1 throughout the data bytes while spi_csn is low. Each data bit changes only after a falling spi_sclk edge, or when spi_csn falls to resume, so the bit is steady at the host's next rising edge.
- R8: In a fixed-length frame the host may raise spi_csn on a byte boundary, between the two command bytes or between data bytes. The frame resumes at the same point when spi_csn returns low.
- R9: If spi_csn rises while a byte is partly shifted, the frame is dropped. The partial byte is not stored, and the next low period starts with a fresh command.
- R10: Bit 0 of register 0 selects the bit order (1 = LSB-first). The other bits of register 0 always read 0. The order is captured when a frame starts, so it applies from the next frame on. In LSB-first order the command and the data are sent bit 0 first.
- R11: core_rdata always shows the register selected by core_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select from the host |
| spi_sdi | input | 1 | Serial data line, input side |
| spi_sdo | output | 1 | Serial data line, output side |
| spi_sdo_en | output | 1 | Drive enable for the data line during readback |
| core_addr | input | IDX_W | Core read address |
| core_rdata | output | 8 | Core read data |

## Verification
The bench builds the block with NUM_REGS = 8 and two synchronizer stages. With only eight registers, address 9 aliases register 1 in its low bits. That makes it possible to check that unimplemented addresses are fully decoded. A three-byte write that counts down from 7 reaches the top of the map, and a four-byte stream reaches the middle of it. With two synchronizer stages and six system clocks per serial half period, the timing of the readback turnaround can be seen from the pins.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int CMD_W    = 16;
    localparam int ADDR_W   = 13;
    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(BYTE_W);

    localparam logic [1:0] LEN_STREAM = 2'b11;

    // register 0 holds the bit-order control in bit 0
    localparam logic [ADDR_W-1:0] CFG_ADDR = '0;
    localparam logic [BYTE_W-1:0] CFG_MASK = 8'h01;

    typedef enum logic [1:0] {
        PH_CMD_A = 2'd0,   // first command byte
        PH_CMD_B = 2'd1,   // second command byte
        PH_DATA  = 2'd2    // data bytes
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic [1:0]        len;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic [BYTE_W-1:0] byte_shift(
        input logic [BYTE_W-1:0] cur, input logic b, input logic lsb);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic [CMD_W-1:0] cmd_shift(
        input logic [CMD_W-1:0] cur, input logic b, input logic lsb);
        return lsb ? {b, cur[CMD_W-1:1]} : {cur[CMD_W-2:0], b};
    endfunction

    function automatic logic pick_bit(
        input logic [BYTE_W-1:0] v, input logic [BITCNT_W-1:0] idx, input logic lsb);
        return lsb ? v[idx] : v[BYTE_W-1-int'(idx)];
    endfunction

    function automatic logic [ADDR_W-1:0] step_addr(
        input logic [ADDR_W-1:0] a, input logic lsb);
        return lsb ? a + 1'b1 : a - 1'b1;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_raw,
    input  logic csn_raw,
    input  logic sdi_raw,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_act,
    output logic sdi_s
);
    localparam int NPIN     = 3;
    localparam int PIN_SCLK = 2;
    localparam int PIN_CSN  = 1;
    localparam int PIN_SDI  = 0;
    localparam logic [NPIN-1:0] PINS_IDLE = 3'b010;

    logic [STAGES-1:0][NPIN-1:0] pipe;
    logic [NPIN-1:0]             cur;
    logic                        sclk_d;
    logic                        csn_d;

    assign cur = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= {STAGES{PINS_IDLE}};
            sclk_d <= 1'b0;
            csn_d  <= 1'b1;
        end else begin
            pipe   <= {pipe[STAGES-2:0], {sclk_raw, csn_raw, sdi_raw}};
            sclk_d <= cur[PIN_SCLK];
            csn_d  <= cur[PIN_CSN];
        end
    end

    assign sclk_rise =  cur[PIN_SCLK] & ~sclk_d;
    assign sclk_fall = ~cur[PIN_SCLK] &  sclk_d;
    assign cs_fall   = ~cur[PIN_CSN]  &  csn_d;
    assign cs_rise   =  cur[PIN_CSN]  & ~csn_d;
    assign cs_act    = ~cur[PIN_CSN];
    assign sdi_s     =  cur[PIN_SDI];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter  int NUM_REGS = 16,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int SLOTS    = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_req_t             wr,
    input  logic [ADDR_W-1:0]   ser_addr,
    output logic [BYTE_W-1:0]   ser_rdata,
    input  logic [IDX_W-1:0]    core_addr,
    output logic [BYTE_W-1:0]   core_rdata,
    output logic                cfg_lsb
);
    logic [SLOTS-1:0][BYTE_W-1:0] regs;
    logic                         wr_hit;
    logic                         rd_hit;

    assign wr_hit = wr.en && (wr.addr[ADDR_W-1:IDX_W] == '0);
    assign rd_hit = (ser_addr[ADDR_W-1:IDX_W] == '0);

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            if (i < NUM_REGS) begin : g_real
                localparam logic [BYTE_W-1:0] KEEP = (i == int'(CFG_ADDR)) ? CFG_MASK : '1;
                logic [BYTE_W-1:0] q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else if (wr_hit && wr.addr[IDX_W-1:0] == IDX_W'(i)) begin
                        q <= wr.data & KEEP;
                    end
                end
                assign regs[i] = q;
            end else begin : g_hole
                assign regs[i] = '0;
            end
        end
    endgenerate

    assign ser_rdata  = rd_hit ? regs[ser_addr[IDX_W-1:0]] : '0;
    assign core_rdata = regs[core_addr];
    assign cfg_lsb    = regs[CFG_ADDR[IDX_W-1:0]][0];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_reg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_rise,
    input  logic                sclk_fall,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                cs_act,
    input  logic                sdi_s,
    input  logic                cfg_lsb,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output wr_req_t             wr,
    output logic                sdo,
    output logic                sdo_en,
    output phase_e              phase,
    output logic [BITCNT_W-1:0] bit_pos
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);

    phase_e              phase_q;
    logic [BITCNT_W-1:0] bit_q;
    logic [CMD_W-1:0]    cmd_q;
    cmd_t                cur_q;
    logic [1:0]          left_q;
    logic                stream_q;
    logic                lsb_q;
    logic [BYTE_W-1:0]   wsh_q;
    logic [BYTE_W-1:0]   rbyte_q;
    logic                out_q;

    logic                take;
    logic                byte_end;
    logic                abort;
    logic                present;
    logic                idle;
    logic [CMD_W-1:0]    cmd_next;
    logic [BYTE_W-1:0]   wsh_next;
    cmd_t                cmd_dec;

    assign take     = sclk_rise & cs_act;
    assign byte_end = take & (bit_q == LAST_BIT);
    assign idle     = (phase_q == PH_CMD_A) && (bit_q == '0);
    // mid-byte select release drops the frame; in a stream it simply ends it
    assign abort    = cs_rise & ((bit_q != '0) | ((phase_q == PH_DATA) & stream_q));
    assign present  = ((sclk_fall & cs_act) | cs_fall) & (phase_q == PH_DATA) & cur_q.rd;
    assign cmd_next = cmd_shift(cmd_q, sdi_s, lsb_q);
    assign wsh_next = byte_shift(wsh_q, sdi_s, lsb_q);
    assign cmd_dec  = cmd_t'(cmd_next);

    assign wr.en   = byte_end && (phase_q == PH_DATA) && !cur_q.rd;
    assign wr.addr = cur_q.addr;
    assign wr.data = wsh_next;

    assign rd_addr = cur_q.addr;
    assign sdo     = out_q;
    assign sdo_en  = cs_act && (phase_q == PH_DATA) && cur_q.rd;
    assign phase   = phase_q;
    assign bit_pos = bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_CMD_A;
            bit_q    <= '0;
            cmd_q    <= '0;
            cur_q    <= '0;
            left_q   <= '0;
            stream_q <= 1'b0;
            lsb_q    <= 1'b0;
            wsh_q    <= '0;
            rbyte_q  <= '0;
            out_q    <= 1'b0;
        end else if (abort) begin
            phase_q  <= PH_CMD_A;
            bit_q    <= '0;
            stream_q <= 1'b0;
        end else begin
            if (idle) begin
                lsb_q <= cfg_lsb;
            end
            if (take) begin
                bit_q <= bit_q + 1'b1;
                unique case (phase_q)
                    PH_CMD_A: begin
                        cmd_q <= cmd_next;
                        if (bit_q == LAST_BIT) phase_q <= PH_CMD_B;
                    end
                    PH_CMD_B: begin
                        cmd_q <= cmd_next;
                        if (bit_q == LAST_BIT) begin
                            cur_q    <= cmd_dec;
                            stream_q <= (cmd_dec.len == LEN_STREAM);
                            left_q   <= (cmd_dec.len == LEN_STREAM) ? 2'd0 : cmd_dec.len;
                            phase_q  <= PH_DATA;
                        end
                    end
                    default: begin
                        wsh_q <= wsh_next;
                        if (bit_q == LAST_BIT) begin
                            cur_q.addr <= step_addr(cur_q.addr, lsb_q);
                            if (!stream_q) begin
                                if (left_q == 2'd0) phase_q <= PH_CMD_A;
                                else                left_q  <= left_q - 1'b1;
                            end
                        end
                    end
                endcase
            end
            if (present) begin
                out_q <= pick_bit((bit_q == '0) ? rd_data : rbyte_q, bit_q, lsb_q);
                if (bit_q == '0) rbyte_q <= rd_data;
            end
        end
    end

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter  int NUM_REGS    = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int IDX_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_sdi,
    output logic              spi_sdo,
    output logic              spi_sdo_en,
    input  logic [IDX_W-1:0]  core_addr,
    output logic [BYTE_W-1:0] core_rdata
);
    logic                sclk_rise;
    logic                sclk_fall;
    logic                cs_fall;
    logic                cs_rise;
    logic                cs_act;
    logic                sdi_s;
    logic                cfg_lsb;
    logic [ADDR_W-1:0]   rd_addr;
    logic [BYTE_W-1:0]   rd_data;
    wr_req_t             wr;
    phase_e              phase;
    logic [BITCNT_W-1:0] bit_pos;
    logic                in_data;

    assign in_data = (phase == PH_DATA);

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk_raw  (spi_sclk),
        .csn_raw   (spi_csn),
        .sdi_raw   (spi_sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s)
    );

    spi_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s),
        .cfg_lsb   (cfg_lsb),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .sdo       (spi_sdo),
        .sdo_en    (spi_sdo_en),
        .phase     (phase),
        .bit_pos   (bit_pos)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .ser_addr   (rd_addr),
        .ser_rdata  (rd_data),
        .core_addr  (core_addr),
        .core_rdata (core_rdata),
        .cfg_lsb    (cfg_lsb)
    );

endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int BITCNT_W = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                cs_act,
    input logic                cs_rise,
    input logic                sclk_rise,
    input logic                wr_en,
    input logic                sdo_en,
    input logic                in_data,
    input logic [BITCNT_W-1:0] bit_pos
);
    AST_SDO_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> cs_act);                                              // R7

    AST_SDO_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        sdo_en |-> in_data);                                             // R7

    AST_WRITE_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (sclk_rise && cs_act && in_data));                     // R6

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && bit_pos != '0) |=> (bit_pos == '0 && !in_data));     // R9

    AST_BIT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && cs_act) |=> (bit_pos == $past(bit_pos) + 1'b1));   // R2

endmodule

bind spi_reg_slave spi_reg_slave_chk #(.BITCNT_W(spi_reg_pkg::BITCNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_act    (cs_act),
    .cs_rise   (cs_rise),
    .sclk_rise (sclk_rise),
    .wr_en     (wr.en),
    .sdo_en    (spi_sdo_en),
    .in_data   (in_data),
    .bit_pos   (bit_pos)
);

// File: tb/spi_reg_slave_bench.sv
module spi_reg_slave_bench;

    localparam int NREG = 8;
    localparam int IW   = 3;
    localparam int HALF = 6;

    typedef struct packed {
        logic [12:0] addr;
        logic [1:0]  len;
        logic [23:0] data;   // first byte in bits 23:16
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{13'd1, 2'd0, 24'hA50000},
        '{13'd3, 2'd1, 24'h3CC300},
        '{13'd7, 2'd2, 24'h112233},
        '{13'd4, 2'd0, 24'h5A0000}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          csn = 1'b1;
    logic          sdi = 1'b0;
    logic [IW-1:0] core_addr = '0;
    logic          sdo;
    logic          sdo_en;
    logic [7:0]    core_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    spi_reg_slave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) u_spi_reg_slave (
        .clk        (clk),
        .rst        (rst),
        .spi_sclk   (sclk),
        .spi_csn    (csn),
        .spi_sdi    (sdi),
        .spi_sdo    (sdo),
        .spi_sdo_en (sdo_en),
        .core_addr  (core_addr),
        .core_rdata (core_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_on();
        csn = 1'b0;
        wait_clk(10);
    endtask

    task automatic cs_off();
        csn = 1'b1;
        wait_clk(10);
    endtask

    task automatic bit_cycle(input logic b, output logic r, output logic oe);
        sdi = b;
        wait_clk(HALF);
        r  = sdo;
        oe = sdo_en;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic send_cmd(input logic rd, input logic [1:0] len, input logic [12:0] addr,
                            input logic lsb, input logic stall, output logic any_oe);
        logic [15:0] w;
        logic r, oe;
        w = {rd, len, addr};
        any_oe = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (stall && i == 8) begin
                cs_off();
                cs_on();
            end
            bit_cycle(lsb ? w[i] : w[15-i], r, oe);
            any_oe = any_oe | oe;
        end
    endtask

    task automatic xfer_byte(input logic [7:0] wb, input logic lsb,
                             output logic [7:0] rb, output logic all_oe);
        logic r, oe;
        all_oe = 1'b1;
        rb = '0;
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            bit_cycle(wb[idx], r, oe);
            rb[idx] = r;
            all_oe = all_oe & oe;
        end
    endtask

    task automatic peek(input int addr, input logic [7:0] exp, input string req);
        core_addr = IW'(addr);
        wait_clk(1);
        check(req, core_rdata, exp);
    endtask

    task automatic write_frame(input logic [12:0] addr, input logic [1:0] len,
                               input logic lsb, input logic [23:0] data);
        logic any_oe, all_oe;
        logic [7:0] rb;
        cs_on();
        send_cmd(1'b0, len, addr, lsb, 1'b0, any_oe);
        for (int b = 0; b <= int'(len); b++) xfer_byte(data[23-8*b -: 8], lsb, rb, all_oe);
        cs_off();
    endtask

    task automatic read_frame(input logic [12:0] addr, input logic [1:0] len,
                              input logic lsb, input logic [23:0] exp, input string req);
        logic any_oe, all_oe;
        logic [7:0] rb;
        cs_on();
        send_cmd(1'b1, len, addr, lsb, 1'b0, any_oe);
        check("R7 no drive during command", any_oe, 1'b0);
        for (int b = 0; b <= int'(len); b++) begin
            xfer_byte(8'h00, lsb, rb, all_oe);
            check(req, rb, exp[23-8*b -: 8]);
            check("R7 drive during data", all_oe, 1'b1);
        end
        cs_off();
    endtask

    initial begin
        logic any_oe, all_oe, r, oe;
        logic [7:0] rb;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1: reset state
        check("R1 sdo_en after reset", sdo_en, 1'b0);
        for (int a = 0; a < NREG; a++) peek(a, 8'h00, "R1 register cleared");

        // vector table: write frame, core check, read frame (R3 R5 R6 R11)
        for (int v = 0; v < 4; v++) begin
            write_frame(VECS[v].addr, VECS[v].len, 1'b0, VECS[v].data);
            for (int b = 0; b <= int'(VECS[v].len); b++)
                peek(int'(VECS[v].addr) - b, VECS[v].data[23-8*b -: 8], "R5 R11 core view after write");
            read_frame(VECS[v].addr, VECS[v].len, 1'b0, VECS[v].data, "R3 readback");
        end

        // R2: clocking with select high does nothing
        send_cmd(1'b0, 2'd0, 13'd1, 1'b0, 1'b0, any_oe);
        xfer_byte(8'hFF, 1'b0, rb, all_oe);
        wait_clk(10);
        peek(1, 8'hA5, "R2 clock ignored while deselected");

        // R3: select held low across two fixed frames
        cs_on();
        send_cmd(1'b0, 2'd0, 13'd3, 1'b0, 1'b0, any_oe);
        xfer_byte(8'h11, 1'b0, rb, all_oe);
        send_cmd(1'b0, 2'd0, 13'd2, 1'b0, 1'b0, any_oe);
        xfer_byte(8'h22, 1'b0, rb, all_oe);
        cs_off();
        peek(3, 8'h11, "R3 back-to-back frame one");
        peek(2, 8'h22, "R3 back-to-back frame two");

        // R8: stall between command bytes and between data bytes
        cs_on();
        send_cmd(1'b0, 2'd1, 13'd6, 1'b0, 1'b1, any_oe);
        xfer_byte(8'h61, 1'b0, rb, all_oe);
        cs_off();
        cs_on();
        xfer_byte(8'h62, 1'b0, rb, all_oe);
        cs_off();
        peek(6, 8'h61, "R8 stalled write first byte");
        peek(5, 8'h62, "R8 stalled write second byte");
        cs_on();
        send_cmd(1'b1, 2'd1, 13'd6, 1'b0, 1'b0, any_oe);
        xfer_byte(8'h00, 1'b0, rb, all_oe);
        check("R8 stalled read first byte", rb, 8'h61);
        cs_off();
        cs_on();
        check("R7 drive resumes after stall", sdo_en, 1'b1);
        xfer_byte(8'h00, 1'b0, rb, all_oe);
        check("R8 stalled read second byte", rb, 8'h62);
        cs_off();

        // R4: streaming write ended by select
        cs_on();
        send_cmd(1'b0, 2'd3, 13'd7, 1'b0, 1'b0, any_oe);
        xfer_byte(8'h71, 1'b0, rb, all_oe);
        xfer_byte(8'h72, 1'b0, rb, all_oe);
        xfer_byte(8'h73, 1'b0, rb, all_oe);
        xfer_byte(8'h74, 1'b0, rb, all_oe);
        cs_off();
        peek(7, 8'h71, "R4 stream byte 0");
        peek(6, 8'h72, "R4 stream byte 1");
        peek(5, 8'h73, "R4 stream byte 2");
        peek(4, 8'h74, "R4 stream byte 3");
        cs_on();
        send_cmd(1'b1, 2'd3, 13'd6, 1'b0, 1'b0, any_oe);
        xfer_byte(8'h00, 1'b0, rb, all_oe);
        check("R4 stream read byte 0", rb, 8'h72);
        xfer_byte(8'h00, 1'b0, rb, all_oe);
        check("R4 stream read byte 1", rb, 8'h73);
        cs_off();

        // R9: abort inside a data byte and inside the command
        cs_on();
        send_cmd(1'b0, 2'd0, 13'd4, 1'b0, 1'b0, any_oe);
        for (int i = 0; i < 4; i++) bit_cycle(1'b1, r, oe);
        cs_off();
        peek(4, 8'h74, "R9 partial byte discarded");
        cs_on();
        for (int i = 0; i < 5; i++) bit_cycle(1'b1, r, oe);
        cs_off();
        write_frame(13'd4, 2'd0, 1'b0, 24'h440000);
        peek(4, 8'h44, "R9 fresh frame after abort");

        // R6: unimplemented addresses
        write_frame(13'd9, 2'd0, 1'b0, 24'h5C0000);
        peek(1, 8'hA5, "R6 alias untouched");
        read_frame(13'd9, 2'd0, 1'b0, 24'h000000, "R6 hole reads zero");
        read_frame(13'h1FFF, 2'd0, 1'b0, 24'h000000, "R6 top address reads zero");

        // R10 R5: switch to LSB-first, ascending addresses
        write_frame(13'd0, 2'd0, 1'b0, 24'hFF0000);
        peek(0, 8'h01, "R10 config keeps only bit 0");
        write_frame(13'd2, 2'd1, 1'b1, 24'h123400);
        peek(2, 8'h12, "R10 R5 lsb-first byte 0");
        peek(3, 8'h34, "R10 R5 lsb-first byte 1 ascending");
        read_frame(13'd0, 2'd0, 1'b1, 24'h010000, "R10 config readback lsb-first");
        write_frame(13'd0, 2'd0, 1'b1, 24'h000000);
        read_frame(13'd2, 2'd0, 1'b0, 24'h120000, "R10 back to msb-first");

        // R4: select held low, stream never ends
        cs_on();
        send_cmd(1'b0, 2'd3, 13'd6, 1'b0, 1'b0, any_oe);
        xfer_byte(8'hAA, 1'b0, rb, all_oe);
        xfer_byte(8'hBB, 1'b0, rb, all_oe);
        xfer_byte(8'h00, 1'b0, rb, all_oe);
        xfer_byte(8'h03, 1'b0, rb, all_oe);
        wait_clk(10);
        peek(6, 8'hAA, "R4 held stream byte 0");
        peek(4, 8'h00, "R4 command-like bits stay data");
        peek(3, 8'h03, "R4 command-like bits stay data");
        csn = 1'b1;
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        peek(6, 8'h00, "R1 reset clears after stream");
        check("R1 sdo_en after second reset", sdo_en, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule